// File: doc/BRIEF.md
# Switched-Capacitor Column Two-Phase Clock Generator

This block produces the two non-overlapping phase clocks that drive two switched-capacitor analog columns. It also produces, for each column, the strobe that connects the column amplifier to its output bus. Each column picks one of four source clocks. Two of them are global system clocks, brought in as `sysclk_a` and `sysclk_b`. The other two are auxiliary clocks, and each auxiliary clock is chosen from eight digital-block clock outputs. The chosen source is divided by four. The first of every four source periods becomes phase one, the third becomes phase two, and the second and fourth are dead gaps.

All logic runs on one fast system clock `clk`. Each source clock is sampled on `clk`, and its rising and falling edges are detected from those samples. Two write-only control registers hold the source selections, the auxiliary-clock picks and a global hold-disable flag. In normal operation an enabled output is connected only in the second half of phase two. The bus then keeps the value it last took during the rest of the cycle, which gives a sample-and-hold. A per-column phase-mode input widens the window to both phases. The global hold-disable flag widens it to the whole of phase two.

Top module: `sc_colclk_gen`

## Requirements
- R1: After reset both control registers are zero. Until the first write, both columns run from `sysclk_a`, both auxiliary picks are digital clock 0, and hold-disable is off.
- R2: A write with `wr_en`=1 and `wr_addr`=0 loads the column-select register. Column 0's select is `wr_data[1:0]` and column 1's select is `wr_data[3:2]`. The select codes are 00 for `sysclk_a`, 01 for `sysclk_b`, 10 for auxiliary clock 0 and 11 for auxiliary clock 1.
- R3: A write with `wr_addr`=1 loads the auxiliary register. Auxiliary clock 0 is `dblk_clk[wr_data[2:0]]`, auxiliary clock 1 is `dblk_clk[wr_data[5:3]]`, and `wr_data[6]` is the hold-disable flag. Both registers take new values at the `clk` edge that samples the write.
- R4: Rising edges of the selected source are counted modulo four. The count is 0 at the first rising edge after reset. `phi1` is high while the count is 0 and `phi2` is high while the count is 2. Both outputs change at the `clk` edge that first samples the new source level.
- R5: `phi1` and `phi2` are never high together. `phi1` falling is never followed in the same cycle by `phi2` rising.
- R6: With phase-mode 0 and hold-disable 0, `bus_conn` is high only when `amp_oe` is high and `phi2` is high, and only after the selected source has fallen within that `phi2` period.
- R7: With phase-mode 1, `bus_conn` equals `amp_oe` AND (`phi1` OR `phi2`). This holds whatever the hold-disable flag is.
- R8: With phase-mode 0 and hold-disable 1, `bus_conn` equals `amp_oe` AND `phi2`.
- R9: `bus_conn` is low whenever the column's `amp_oe` is low.
- R10: While `rst_n` is low, `phi1`, `phi2` and `bus_conn` are all low on every column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all source clocks |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the column-select register, 1 selects the auxiliary register |
| wr_data | input | 8 | Write data |
| sysclk_a | input | 1 | Global system clock, select code 00 |
| sysclk_b | input | 1 | Global system clock, select code 01 |
| dblk_clk | input | 8 | Digital-block clock outputs that can feed the auxiliary clocks |
| amp_oe | input | 2 | Amplifier output enable, one bit per column |
| phase_mode | input | 2 | Connect in both phases, one bit per column |
| phi1 | output | 2 | Phase-one clock, one bit per column |
| phi2 | output | 2 | Phase-two clock, one bit per column |
| bus_conn | output | 2 | Output-bus connect strobe, one bit per column |

## Verification
The bench drives ten source clocks with different periods and steps through every column select, several auxiliary picks, both hold-disable states and all phase-mode and enable patterns. It compares each column against a reference model every cycle. The main corner is the falling edge inside phase two. A design that marks the late half on the wrong edge would connect the bus during the first half of phase two, or never connect it at all. The bench also changes the select while the divider is running, and resets in the middle of a run. A divider that mishandles the sample taken under the old select would slip by one phase. A design that does not clear the registers on reset would keep following the old source.

// File: rtl/scc_pkg.sv
// Shared constants and types for the switched-capacitor column clock generator.
// Assumes the divide ratio is even, so that phase two sits in the middle of the cycle.
package scc_pkg;
    localparam int REG_W      = 8;
    localparam int NUM_AUX    = 2;
    localparam int SRC_SEL_W  = 2;
    localparam int DIV_RATIO  = 4;
    localparam int PH1_SLOT   = 0;
    localparam int PH2_SLOT   = DIV_RATIO / 2;

    typedef enum logic [SRC_SEL_W-1:0] {
        SRC_SYS_A = 2'b00,
        SRC_SYS_B = 2'b01,
        SRC_AUX_0 = 2'b10,
        SRC_AUX_1 = 2'b11
    } src_sel_e;
endpackage

// File: rtl/scc_ctrl_regs.sv
// Two write-only control registers: the per-column source selects, and the
// auxiliary picks with the hold-disable flag. Assumes the fields fit in REG_W bits.
module scc_ctrl_regs
    import scc_pkg::*;
#(
    parameter int NUM_COLS = 2,
    parameter int IDX_W    = 3
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic                                 wr_addr,
    input  logic [REG_W-1:0]                     wr_data,
    output logic [NUM_COLS*SRC_SEL_W-1:0]        col_sel,
    output logic [NUM_AUX-1:0][IDX_W-1:0]        aux_idx,
    output logic                                 hold_off
);
    localparam int SEL_BITS = NUM_COLS * SRC_SEL_W;
    localparam int AUX_BITS = NUM_AUX * IDX_W;

    logic [SEL_BITS-1:0] sel_q;
    logic [AUX_BITS-1:0] aux_q;
    logic                hold_q;
    logic                unused_wr;

    // Upper data bits that no field uses are ignored.
    assign unused_wr = ^wr_data;

    // Column-select register, written when the address is 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (wr_en && !wr_addr)
            sel_q <= wr_data[SEL_BITS-1:0];
    end

    // Auxiliary register, written when the address is 1. The hold flag sits just above the picks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aux_q  <= '0;
            hold_q <= 1'b0;
        end else if (wr_en && wr_addr) begin
            aux_q  <= wr_data[AUX_BITS-1:0];
            hold_q <= wr_data[AUX_BITS];
        end
    end

    // Split the register contents into their fields.
    always_comb begin
        col_sel  = sel_q;
        aux_idx  = aux_q;
        hold_off = hold_q;
    end
endmodule

// File: rtl/scc_aux_sel.sv
// Chooses each auxiliary clock from the digital-block clock outputs.
// Purely combinational. Assumes NUM_DBLK is a power of two, so every pick is in range.
module scc_aux_sel
    import scc_pkg::*;
#(
    parameter int NUM_DBLK = 8,
    parameter int IDX_W    = 3
) (
    input  logic [NUM_DBLK-1:0]           dblk_clk,
    input  logic [NUM_AUX-1:0][IDX_W-1:0] aux_idx,
    output logic [NUM_AUX-1:0]            aux_clk
);
    for (genvar a = 0; a < NUM_AUX; a++) begin : g_aux
        // One multiplexer for each auxiliary clock.
        assign aux_clk[a] = dblk_clk[aux_idx[a]];
    end
endmodule

// File: rtl/scc_col_engine.sv
// One column: selects its source, detects the source edges on clk, and divides by
// DIV_RATIO into non-overlapping phases. It also marks the late half of phase two and
// forms the bus-connect window. Assumes each source level is held for at least one clk cycle.
module scc_col_engine
    import scc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3:0]           srcs,
    input  logic [SRC_SEL_W-1:0] sel,
    input  logic                 hold_off,
    input  logic                 amp_oe,
    input  logic                 phase_mode,
    output logic                 phi1,
    output logic                 phi2,
    output logic                 bus_conn
);
    localparam int CNT_W = $clog2(DIV_RATIO);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_RATIO - 1);
    localparam logic [CNT_W-1:0] CNT_PH1  = CNT_W'(PH1_SLOT);
    localparam logic [CNT_W-1:0] CNT_PH2  = CNT_W'(PH2_SLOT);

    logic             src_now;
    logic             src_q;
    logic             rise;
    logic             fall;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             phi1_q;
    logic             phi2_q;
    logic             late_q;

    // Source multiplexer, decoded by the select code.
    always_comb begin
        case (src_sel_e'(sel))
            SRC_SYS_A: src_now = srcs[0];
            SRC_SYS_B: src_now = srcs[1];
            SRC_AUX_0: src_now = srcs[2];
            default:   src_now = srcs[3];
        endcase
    end

    // Holds the level seen at the previous clk edge, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            src_q <= 1'b0;
        else
            src_q <= src_now;
    end

    assign rise    = src_now & ~src_q;
    assign fall    = ~src_now & src_q;
    assign cnt_nxt = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;

    // Divider: advances on each source rise. The phases are decoded into registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= CNT_LAST;
            phi1_q <= 1'b0;
            phi2_q <= 1'b0;
        end else if (rise) begin
            cnt_q  <= cnt_nxt;
            phi1_q <= (cnt_nxt == CNT_PH1);
            phi2_q <= (cnt_nxt == CNT_PH2);
        end
    end

    // Late-half marker: set by a source fall during phase two, cleared by the next rise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            late_q <= 1'b0;
        else if (rise)
            late_q <= 1'b0;
        else if (fall && phi2_q)
            late_q <= 1'b1;
    end

    // Connect window. Phase mode takes precedence over hold-disable, which takes precedence over sample-and-hold.
    always_comb begin
        if (!amp_oe)
            bus_conn = 1'b0;
        else if (phase_mode)
            bus_conn = phi1_q | phi2_q;
        else if (hold_off)
            bus_conn = phi2_q;
        else
            bus_conn = phi2_q & late_q;
    end

    assign phi1 = phi1_q;
    assign phi2 = phi2_q;
endmodule

// File: rtl/sc_colclk_gen.sv
// Top level: the control registers, the auxiliary clock picks, and one column engine per column.
// Assumes NUM_COLS*2 and NUM_AUX*IDX_W+1 each fit in the 8-bit write data.
module sc_colclk_gen
    import scc_pkg::*;
#(
    parameter int NUM_COLS = 2,
    parameter int NUM_DBLK = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_addr,
    input  logic [REG_W-1:0]    wr_data,
    input  logic                sysclk_a,
    input  logic                sysclk_b,
    input  logic [NUM_DBLK-1:0] dblk_clk,
    input  logic [NUM_COLS-1:0] amp_oe,
    input  logic [NUM_COLS-1:0] phase_mode,
    output logic [NUM_COLS-1:0] phi1,
    output logic [NUM_COLS-1:0] phi2,
    output logic [NUM_COLS-1:0] bus_conn
);
    localparam int IDX_W = $clog2(NUM_DBLK);

    logic [NUM_COLS*SRC_SEL_W-1:0] col_sel;
    logic [NUM_AUX-1:0][IDX_W-1:0] aux_idx;
    logic                          hold_off;
    logic [NUM_AUX-1:0]            aux_clk;
    logic [3:0]                    srcs;

    scc_ctrl_regs #(
        .NUM_COLS (NUM_COLS),
        .IDX_W    (IDX_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .col_sel  (col_sel),
        .aux_idx  (aux_idx),
        .hold_off (hold_off)
    );

    scc_aux_sel #(
        .NUM_DBLK (NUM_DBLK),
        .IDX_W    (IDX_W)
    ) u_aux (
        .dblk_clk (dblk_clk),
        .aux_idx  (aux_idx),
        .aux_clk  (aux_clk)
    );

    // The four candidate sources, in select-code order.
    assign srcs = {aux_clk[1], aux_clk[0], sysclk_b, sysclk_a};

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        scc_col_engine u_col (
            .clk        (clk),
            .rst_n      (rst_n),
            .srcs       (srcs),
            .sel        (col_sel[c*SRC_SEL_W +: SRC_SEL_W]),
            .hold_off   (hold_off),
            .amp_oe     (amp_oe[c]),
            .phase_mode (phase_mode[c]),
            .phi1       (phi1[c]),
            .phi2       (phi2[c]),
            .bus_conn   (bus_conn[c])
        );
    end
endmodule

// File: rtl/scc_colclk_chk.sv
// Property checker for sc_colclk_gen: phase exclusion, connect-window bounds and
// reset quiet. It is attached with bind and reads the hold-disable state of the top.
module scc_colclk_chk #(
    parameter int NUM_COLS = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_COLS-1:0] amp_oe,
    input logic [NUM_COLS-1:0] phase_mode,
    input logic [NUM_COLS-1:0] phi1,
    input logic [NUM_COLS-1:0] phi2,
    input logic [NUM_COLS-1:0] bus_conn,
    input logic                hold_off
);
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_chk
        AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(phi1[c] && phi2[c])); // R5
        AST_GAP_AFTER_PHI1: assert property (@(posedge clk) disable iff (!rst_n) $fell(phi1[c]) |-> !phi2[c]); // R5
        AST_CONN_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n) bus_conn[c] |-> amp_oe[c]); // R9
        AST_CONN_PHI2_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (bus_conn[c] && !phase_mode[c]) |-> phi2[c]); // R6
        AST_PM_FULL: assert property (@(posedge clk) disable iff (!rst_n) (phase_mode[c] && amp_oe[c] && (phi1[c] || phi2[c])) |-> bus_conn[c]); // R7
        AST_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n) (hold_off && amp_oe[c] && phi2[c]) |-> bus_conn[c]); // R8
        AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!phi1[c] && !phi2[c] && !bus_conn[c])); // R10
    end
endmodule

bind sc_colclk_gen scc_colclk_chk #(.NUM_COLS(NUM_COLS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .amp_oe     (amp_oe),
    .phase_mode (phase_mode),
    .phi1       (phi1),
    .phi2       (phi2),
    .bus_conn   (bus_conn),
    .hold_off   (hold_off)
);

// File: tb/sim_sc_colclk_gen.sv
// Scoreboard bench. The step task drives the clocks and writes, runs a reference model
// and queues the expected outputs. A monitor pops one item per cycle and compares it.
module sim_sc_colclk_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       sysclk_a = 1'b0;
    logic       sysclk_b = 1'b0;
    logic [7:0] dblk_clk = '0;
    logic [1:0] amp_oe = '0;
    logic [1:0] phase_mode = '0;
    wire  [1:0] phi1;
    wire  [1:0] phi2;
    wire  [1:0] bus_conn;

    sc_colclk_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sysclk_a(sysclk_a), .sysclk_b(sysclk_b), .dblk_clk(dblk_clk),
        .amp_oe(amp_oe), .phase_mode(phase_mode),
        .phi1(phi1), .phi2(phi2), .bus_conn(bus_conn)
    );

    always #4 clk = ~clk;   // 125 MHz

    typedef struct {
        logic [1:0] p1;
        logic [1:0] p2;
        logic [1:0] cn;
        int         ptag[2];
        int         ctag[2];
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   tk = 0;
    bit   touched = 0;
    int   mk[2];
    bit   m1[2], m2[2], mlate[2], mprev[2];
    int   b_sel[2], b_aux[2];
    bit   b_hold;
    logic [1:0] nxt_oe = 2'b11;
    logic [1:0] nxt_pm = 2'b00;

    function automatic string tname(int n);
        case (n)
            1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
            5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
            9: return "R9";  default: return "R10";
        endcase
    endfunction

    task automatic chk(bit ok, int r, string what, logic a, logic e);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tname(r), what, a, e, $time);
        end
    endtask

    function automatic bit lvl(int h);
        return ((tk / h) % 2) == 1;
    endfunction

    function automatic bit sel_lvl(int c);
        case (b_sel[c])
            0: return sysclk_a;
            1: return sysclk_b;
            2: return dblk_clk[b_aux[0]];
            default: return dblk_clk[b_aux[1]];
        endcase
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            mk[c] = 3; m1[c] = 0; m2[c] = 0; mlate[c] = 0; mprev[c] = 0;
            b_sel[c] = 0; b_aux[c] = 0;
        end
        b_hold = 0;
        touched = 0;
    endtask

    // Driver: one clk cycle of stimulus, plus the expected outputs after the next edge.
    task automatic step(bit w, bit a, logic [7:0] d);
        exp_t e;
        @(negedge clk);
        tk++;
        sysclk_a = lvl(2);
        sysclk_b = lvl(3);
        for (int i = 0; i < 8; i++) dblk_clk[i] = lvl(i + 4);
        wr_en = w; wr_addr = a; wr_data = d;
        amp_oe = nxt_oe; phase_mode = nxt_pm;
        // R4: the divider advances on each source rise seen under the select in force at the edge
        for (int c = 0; c < 2; c++) begin
            bit lv;
            lv = sel_lvl(c);
            if (lv && !mprev[c]) begin
                mk[c] = (mk[c] + 1) % 4;
                m1[c] = (mk[c] == 0);
                m2[c] = (mk[c] == 2);
                mlate[c] = 0;
            end else if (!lv && mprev[c] && m2[c]) begin
                mlate[c] = 1;
            end
            mprev[c] = lv;
        end
        if (w) begin
            touched = 1;
            if (!a) begin
                b_sel[0] = int'(d[1:0]); b_sel[1] = int'(d[3:2]);        // R2
            end else begin
                b_aux[0] = int'(d[2:0]); b_aux[1] = int'(d[5:3]);        // R3
                b_hold = d[6];                                           // R8
            end
        end
        for (int c = 0; c < 2; c++) begin
            e.p1[c] = m1[c];
            e.p2[c] = m2[c];
            if (!amp_oe[c]) begin
                e.cn[c] = 0; e.ctag[c] = 9;                              // R9
            end else if (phase_mode[c]) begin
                e.cn[c] = m1[c] | m2[c]; e.ctag[c] = 7;                  // R7
            end else if (b_hold) begin
                e.cn[c] = m2[c]; e.ctag[c] = 8;
            end else begin
                e.cn[c] = m2[c] & mlate[c]; e.ctag[c] = 6;               // R6
            end
            if (!touched) e.ptag[c] = 1;                                 // R1
            else if (b_sel[c] >= 2) e.ptag[c] = 3;
            else if (b_sel[c] == 1) e.ptag[c] = 2;
            else e.ptag[c] = 4;
        end
        q.push_back(e);
    endtask

    // R10: hold reset for three cycles and check that every output is quiet.
    task automatic reset_dut();
        @(negedge clk);
        rst_n = 0; wr_en = 0; amp_oe = 2'b11; phase_mode = 2'b11;
        repeat (3) @(posedge clk);
        #2;
        for (int c = 0; c < 2; c++) begin
            chk(phi1[c] === 1'b0, 10, "phi1 in reset", phi1[c], 1'b0);
            chk(phi2[c] === 1'b0, 10, "phi2 in reset", phi2[c], 1'b0);
            chk(bus_conn[c] === 1'b0, 10, "bus_conn in reset", bus_conn[c], 1'b0);
        end
        @(negedge clk);
        model_reset();
        rst_n = 1;
    endtask

    // Monitor: compares one queued item per cycle, between the rising and the falling edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                for (int c = 0; c < 2; c++) begin
                    chk(phi1[c] === e.p1[c], e.ptag[c], "phi1", phi1[c], e.p1[c]);
                    chk(phi2[c] === e.p2[c], e.ptag[c], "phi2", phi2[c], e.p2[c]);
                    chk(bus_conn[c] === e.cn[c], e.ctag[c], "bus_conn", bus_conn[c], e.cn[c]);
                    chk(!(phi1[c] && phi2[c]), 5, "overlap", phi1[c] & phi2[c], 1'b0);   // R5
                end
            end
        end
    end

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        nxt_oe = 2'b11; nxt_pm = 2'b00;
        reset_dut();
        // R1: defaults with no write
        repeat (60) step(0, 0, 8'h00);
        for (int s = 0; s < 4; s++) begin
            for (int h = 0; h < 2; h++) begin
                for (int p = 0; p < 4; p++) begin
                    logic [2:0] a0, a1;
                    a0 = 3'((s * 3 + h) % 8);
                    a1 = 3'((s * 5 + p + 1) % 8);
                    step(1, 0, {4'h0, 2'(3 - s), 2'(s)});
                    nxt_oe = (p == 3) ? 2'b01 : 2'b11;
                    nxt_pm = (p == 1) ? 2'b01 : (p == 2) ? 2'b11 : (p == 3) ? 2'b10 : 2'b00;
                    step(1, 1, {1'b0, 1'(h), a1, a0});
                    repeat (48) step(0, 0, 8'h00);
                end
            end
        end
        // R10: a reset in the middle of a run restarts the divider and clears the registers
        nxt_oe = 2'b11; nxt_pm = 2'b00;
        reset_dut();
        repeat (40) step(0, 0, 8'h00);
        repeat (3) @(posedge clk);
        #4;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule